// File: doc/BRIEF.md
# Configurable Serial Frame Transmitter

This block takes one character at a time from a valid/ready input and sends it on a single serial output line. It adds a low start bit, then 5 to 9 data bits sent least significant first. An optional even or odd parity bit follows the data, and the frame closes with one or two high stop bits. The character format is chosen by static configuration inputs, and all thirty combinations of size, parity and stop count are legal.

Each bit lasts `2*(cfg_div+1)` system clocks. In asynchronous operation that period is the whole of the timing. In synchronous master operation the block also drives a serial clock output. At the start of every bit that clock moves to its active level, and half-way through the bit it returns to its idle level. The polarity input selects the idle level, so the serial line changes on the rising clock edge when polarity is 0 and on the falling edge when polarity is 1.

The format, the divisor and the character are all captured in the cycle the character is accepted. A change on those inputs during a frame therefore does not disturb the frame in flight. When a new character is offered in time, the next frame follows the last stop bit with no idle gap.

Top module: `sfrm_tx`

## Requirements
- R1: After reset, and whenever no frame is in progress, `txd` is 1, `busy` is 0 and `in_ready` is 1.
- R2: A character is accepted in a cycle where `in_valid` and `in_ready` are both 1. From the next cycle, `busy` is 1 and `txd` carries a start bit of value 0 for one bit period.
- R3: After the start bit, the data bits go out least significant first. Their count is `cfg_size + 5` for `cfg_size` values 0 to 4, which gives 5 to 9 bits. Any value above 4 gives 9 bits.
- R4: `cfg_parity` selects the parity bit: 2'b00 or 2'b01 gives no parity bit; 2'b10 gives even parity, the XOR of the data bits sent; 2'b11 gives odd parity, the inverse of that XOR. When present, the parity bit follows the last data bit.
- R5: The frame ends with one stop bit of value 1, or two such bits when `cfg_two_stop` is 1.
- R6: Every bit of the frame lasts exactly `2*(cfg_div+1)` clock cycles.
- R7: If a character is offered while the last stop bit is ending, `in_ready` is 1 in that stop bit's final cycle. The next start bit then begins in the cycle right after the stop bit, with no idle time.
- R8: With `cfg_sync` = 1, `xck` is `~pol` during the first `cfg_div+1` cycles of each bit and `pol` during the remaining cycles. `txd` therefore changes on the rising `xck` edge for polarity 0 and on the falling edge for polarity 1.
- R9: While no frame is in progress, `xck` equals the live `cfg_pol`. During an asynchronous frame, `xck` holds the polarity captured at acceptance.
- R10: The format, divisor, polarity, mode and character are captured at acceptance. Input changes during a frame do not alter that frame.
- R11: While a frame is in progress, `in_ready` is 0 except in the final cycle of the last stop bit, and `busy` stays 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Character offered |
| in_ready | output | 1 | Block can take a character this cycle |
| in_data | input | 9 | Character; only the configured low bits are sent |
| cfg_size | input | 3 | Data bit count minus 5 |
| cfg_parity | input | 2 | Parity mode (none, even, odd) |
| cfg_two_stop | input | 1 | Two stop bits when 1 |
| cfg_sync | input | 1 | Synchronous master mode when 1 |
| cfg_pol | input | 1 | Serial clock idle level and polarity |
| cfg_div | input | DIV_W | Bit period is 2*(cfg_div+1) clocks |
| txd | output | 1 | Serial data line |
| xck | output | 1 | Serial clock output |
| busy | output | 1 | Frame in progress |

## Verification
The hardest situation to reach is the seamless hand-over at the end of a frame. A character must be presented exactly when the final stop bit expires, and the new frame may use a different format, mode and polarity. The driver holds `in_valid` high with the next character queued behind a running frame. The handshake then lands on the last cycle of the stop bit. The monitor measures the time from one start edge to the next and compares it with the previous frame's length. Capture-at-acceptance is reached by scrambling every configuration input and the data in the cycle after acceptance, while the monitor still expects the original frame.

// File: rtl/sfrm_pkg.sv
package sfrm_pkg;

    localparam int DATA_MAX  = 9;
    localparam int DATA_MIN  = 5;
    localparam int STOP_MAX  = 2;
    localparam int FRAME_MAX = 1 + DATA_MAX + 1 + STOP_MAX;
    localparam int LEN_W     = $clog2(FRAME_MAX + 1);
    localparam int SIZE_W    = 3;
    localparam int DCNT_W    = $clog2(DATA_MAX + 1);

    typedef enum logic [1:0] {
        PAR_NONE = 2'b00,
        PAR_RSVD = 2'b01,
        PAR_EVEN = 2'b10,
        PAR_ODD  = 2'b11
    } par_e;

    typedef struct packed {
        logic [SIZE_W-1:0] size;
        par_e              par;
        logic              two_stop;
        logic              sync;
        logic              pol;
    } fmt_t;

    function automatic logic [DCNT_W-1:0] data_count(logic [SIZE_W-1:0] s);
        if (s > SIZE_W'(DATA_MAX - DATA_MIN))
            return DCNT_W'(DATA_MAX);
        return DCNT_W'(s) + DCNT_W'(DATA_MIN);
    endfunction

    function automatic logic parity_of(logic [DATA_MAX-1:0] d,
                                       logic [DCNT_W-1:0]   n,
                                       logic                odd);
        logic x;
        x = odd;
        for (int i = 0; i < DATA_MAX; i++)
            if (i < int'(n)) x ^= d[i];
        return x;
    endfunction

endpackage

// File: rtl/sfrm_frame_build.sv
module sfrm_frame_build
    import sfrm_pkg::*;
(
    input  fmt_t                 fmt,
    input  logic [DATA_MAX-1:0]  data,
    output logic [FRAME_MAX-1:0] frame,
    output logic [LEN_W-1:0]     len
);
    logic [DCNT_W-1:0] n;
    logic              par_on;

    always_comb begin
        n      = data_count(fmt.size);
        par_on = fmt.par[1];
        frame  = '1;
        frame[0] = 1'b0;
        for (int i = 0; i < DATA_MAX; i++)
            if (i < int'(n)) frame[1 + i] = data[i];
        if (par_on)
            frame[1 + int'(n)] = parity_of(data, n, fmt.par[0]);
        len = LEN_W'(1) + LEN_W'(n) + LEN_W'(par_on) + LEN_W'(1) + LEN_W'(fmt.two_stop);
    end

endmodule

// File: rtl/sfrm_bit_timer.sv
module sfrm_bit_timer #(
    parameter int DIV_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en,
    input  logic             restart,
    input  logic [DIV_W-1:0] div,
    output logic             bit_end,
    output logic             first_half
);
    localparam int CNT_W = DIV_W + 1;

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] per_end;

    assign per_end    = {div, 1'b1};
    assign bit_end    = en && (cnt_q == per_end);
    assign first_half = (cnt_q <= {1'b0, div});

    always_ff @(posedge clk) begin
        if (rst || restart)
            cnt_q <= '0;
        else if (en)
            cnt_q <= bit_end ? '0 : cnt_q + 1'b1;
    end

    // R6
    cnt_range_chk: assert property (@(posedge clk) disable iff (rst)
        (en && !restart) |=> (cnt_q <= per_end));

    // R6
    cnt_wrap_chk: assert property (@(posedge clk) disable iff (rst)
        (bit_end && !restart) |=> (cnt_q == '0));

endmodule

// File: rtl/sfrm_tx.sv
module sfrm_tx
    import sfrm_pkg::*;
#(
    parameter int DIV_W = 16
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                in_valid,
    output logic                in_ready,
    input  logic [DATA_MAX-1:0] in_data,
    input  logic [SIZE_W-1:0]   cfg_size,
    input  logic [1:0]          cfg_parity,
    input  logic                cfg_two_stop,
    input  logic                cfg_sync,
    input  logic                cfg_pol,
    input  logic [DIV_W-1:0]    cfg_div,
    output logic                txd,
    output logic                xck,
    output logic                busy
);
    fmt_t                 fmt_live, fmt_q;
    logic [DIV_W-1:0]     div_q;
    logic [FRAME_MAX-1:0] frame_w, sh_q;
    logic [LEN_W-1:0]     len_w, left_q;
    logic                 busy_q, txd_q;
    logic                 bit_end, first_half;
    logic                 accept, frame_end;

    always_comb begin
        fmt_live.size     = cfg_size;
        fmt_live.par      = par_e'(cfg_parity);
        fmt_live.two_stop = cfg_two_stop;
        fmt_live.sync     = cfg_sync;
        fmt_live.pol      = cfg_pol;
    end

    sfrm_frame_build u_build (
        .fmt   (fmt_live),
        .data  (in_data),
        .frame (frame_w),
        .len   (len_w)
    );

    sfrm_bit_timer #(.DIV_W(DIV_W)) u_timer (
        .clk        (clk),
        .rst        (rst),
        .en         (busy_q),
        .restart    (accept),
        .div        (div_q),
        .bit_end    (bit_end),
        .first_half (first_half)
    );

    assign frame_end = busy_q && bit_end && (left_q == '0);
    assign in_ready  = !busy_q || frame_end;
    assign accept    = in_valid && in_ready;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_q <= 1'b0;
            txd_q  <= 1'b1;
            sh_q   <= '1;
            left_q <= '0;
            fmt_q  <= '0;
            div_q  <= '0;
        end else if (accept) begin
            busy_q <= 1'b1;
            txd_q  <= frame_w[0];
            sh_q   <= {1'b1, frame_w[FRAME_MAX-1:1]};
            left_q <= len_w - 1'b1;
            fmt_q  <= fmt_live;
            div_q  <= cfg_div;
        end else if (frame_end) begin
            busy_q <= 1'b0;
            txd_q  <= 1'b1;
        end else if (busy_q && bit_end) begin
            txd_q  <= sh_q[0];
            sh_q   <= {1'b1, sh_q[FRAME_MAX-1:1]};
            left_q <= left_q - 1'b1;
        end
    end

    assign txd  = txd_q;
    assign busy = busy_q;

    always_comb begin
        if (!busy_q)
            xck = cfg_pol;
        else if (fmt_q.sync)
            xck = fmt_q.pol ^ first_half;
        else
            xck = fmt_q.pol;
    end

    // R2
    start_low_chk: assert property (@(posedge clk) disable iff (rst)
        accept |=> (busy && !txd));

    // R1
    idle_high_chk: assert property (@(posedge clk) disable iff (rst)
        !busy_q |-> txd);

    // R5
    stop_high_chk: assert property (@(posedge clk) disable iff (rst)
        (busy_q && (left_q == '0 || (fmt_q.two_stop && left_q == LEN_W'(1)))) |-> txd);

    // R8
    xck_edge_chk: assert property (@(posedge clk) disable iff (rst)
        (busy_q && fmt_q.sync && bit_end && !frame_end) |=> (xck != fmt_q.pol));

    // R10
    fmt_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (busy_q && !accept) |=> ($stable(fmt_q) && $stable(div_q)));

    // R11
    ready_low_chk: assert property (@(posedge clk) disable iff (rst)
        (busy_q && !bit_end) |-> !in_ready);

endmodule

// File: tb/sfrm_tx_tb_top.sv
`timescale 1ns/1ps
module sfrm_tx_tb_top;

    localparam int DIV_W = 16;

    typedef struct {
        logic [12:0] bits;
        int          n;
        int          d;
        bit          sync;
        bit          pol;
        bit          b2b;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [8:0]  in_data = '0;
    logic [2:0]  cfg_size = '0;
    logic [1:0]  cfg_parity = '0;
    logic        cfg_two_stop = 1'b0;
    logic        cfg_sync = 1'b0;
    logic        cfg_pol = 1'b0;
    logic [DIV_W-1:0] cfg_div = '0;
    logic        txd, xck, busy;

    int total = 0;
    int passed = 0;
    exp_t q[$];

    always #2.5 clk = ~clk;

    sfrm_tx #(.DIV_W(DIV_W)) dut_i (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
        .in_data(in_data), .cfg_size(cfg_size), .cfg_parity(cfg_parity),
        .cfg_two_stop(cfg_two_stop), .cfg_sync(cfg_sync), .cfg_pol(cfg_pol),
        .cfg_div(cfg_div), .txd(txd), .xck(xck), .busy(busy)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        total++;
        if (ok) passed++;
        else $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    endtask

    function automatic exp_t build(input logic [8:0] data, input int sz, input int par,
                                   input bit ts, input bit sy, input bit po, input int d,
                                   input bit b2b);
        exp_t e;
        int nd;
        logic p;
        nd = (sz > 4) ? 9 : sz + 5;
        e.bits = '1;
        e.bits[0] = 1'b0;
        p = 1'b0;
        for (int i = 0; i < nd; i++) begin
            e.bits[1 + i] = data[i];
            p ^= data[i];
        end
        e.n = 1 + nd + 1 + (ts ? 1 : 0);
        if (par >= 2) begin
            e.bits[1 + nd] = (par == 3) ? ~p : p;
            e.n++;
        end
        e.d = d; e.sync = sy; e.pol = po; e.b2b = b2b;
        return e;
    endfunction

    task automatic send(input logic [8:0] data, input int sz, input int par, input bit ts,
                        input bit sy, input bit po, input int d, input bit b2b,
                        input bit scramble);
        in_data = data; cfg_size = 3'(sz); cfg_parity = 2'(par); cfg_two_stop = ts;
        cfg_sync = sy; cfg_pol = po; cfg_div = DIV_W'(d); in_valid = 1'b1;
        while (!in_ready) @(negedge clk);
        @(posedge clk);
        q.push_back(build(data, sz, par, ts, sy, po, d, b2b));
        @(negedge clk);
        in_valid = 1'b0;
        if (scramble) begin
            // R10: every input changes after acceptance
            in_data = ~data; cfg_size = 3'(4 - sz); cfg_parity = 2'(par ^ 3);
            cfg_two_stop = ~ts; cfg_sync = ~sy; cfg_pol = ~po; cfg_div = DIV_W'(d + 3);
            chk(in_ready == 1'b0, "R11", "ready while busy", in_ready, 0);
            chk(busy == 1'b1, "R11", "busy after accept", busy, 1);
        end
    endtask

    task automatic settle();
        while (busy || q.size() != 0) @(negedge clk);
        repeat (3) @(negedge clk);
        chk(txd == 1'b1, "R1", "idle txd", txd, 1);
        chk(in_ready == 1'b1, "R1", "idle ready", in_ready, 1);
        chk(xck == cfg_pol, "R9", "idle xck", xck, cfg_pol);
    endtask

    // monitor: pops expected frames and compares each bit
    initial begin : monitor
        exp_t e;
        realtime t0, prev_t0;
        int prev_len;
        prev_t0 = 0; prev_len = 0;
        forever begin
            @(negedge clk);
            if (rst || txd !== 1'b0) continue;
            t0 = $realtime;
            if (q.size() == 0) begin
                chk(0, "R1", "unexpected start", 0, 1);
                continue;
            end
            e = q.pop_front();
            if (e.b2b)
                // R7: next start immediately follows last stop
                chk(t0 - prev_t0 == prev_len * 5.0, "R7", "gap in clocks",
                    int'((t0 - prev_t0) / 5.0), int'(prev_len));
            prev_t0 = t0;
            prev_len = e.n * 2 * (e.d + 1);
            for (int i = 0; i < e.n; i++) begin
                if (e.sync)
                    chk(xck == ~e.pol, "R8", "xck at bit start", xck, ~e.pol);
                else
                    chk(xck == e.pol, "R9", "xck async frame", xck, e.pol);
                repeat (e.d + 1) @(negedge clk);
                // R2 start, R3 data, R4 parity, R5 stop, R6 timing
                chk(txd == e.bits[i], (i == 0) ? "R2" : (i == e.n - 1) ? "R5" : "R3/R4",
                    $sformatf("bit %0d", i), txd, e.bits[i]);
                chk(busy == 1'b1, "R11", "busy mid frame", busy, 1);
                if (e.sync)
                    chk(xck == e.pol, "R8", "xck mid bit", xck, e.pol);
                if (i < e.n - 1) repeat (e.d + 1) @(negedge clk);
                else repeat (e.d) @(negedge clk);
            end
        end
    end

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        total++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", passed, total);
        $finish;
    end

    initial begin : driver
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(txd == 1'b1, "R1", "reset txd", txd, 1);
        chk(busy == 1'b0, "R1", "reset busy", busy, 0);
        chk(in_ready == 1'b1, "R1", "reset ready", in_ready, 1);
        chk(xck == cfg_pol, "R9", "reset xck", xck, cfg_pol);

        send(9'h0A5, 3, 0, 0, 0, 0, 1, 0, 0); settle();
        send(9'h013, 0, 2, 1, 0, 1, 0, 0, 1); settle();
        send(9'h1C3, 4, 3, 0, 0, 0, 2, 0, 1); settle();
        send(9'h055, 2, 2, 0, 0, 0, 1, 0, 0); settle();
        send(9'h02D, 1, 3, 1, 0, 0, 0, 0, 1); settle();
        send(9'h0FF, 5, 1, 0, 0, 0, 0, 0, 0); settle();
        send(9'h03C, 3, 2, 0, 1, 0, 1, 0, 1); settle();
        send(9'h0FF, 4, 0, 1, 1, 1, 0, 0, 0); settle();

        send(9'h081, 3, 0, 0, 0, 0, 1, 0, 0);
        send(9'h016, 0, 3, 1, 0, 0, 1, 1, 0);
        send(9'h1A5, 4, 2, 0, 1, 1, 0, 1, 0);
        send(9'h03E, 2, 0, 1, 1, 0, 2, 1, 0);
        settle();

        for (int sz = 0; sz < 5; sz++)
            for (int pi = 0; pi < 3; pi++)
                for (int ts = 0; ts < 2; ts++)
                    send(9'(9'h12B ^ (sz * 37 + pi * 11 + ts * 5)), sz,
                         (pi == 0) ? 0 : pi + 1, ts[0], 0, 0, 0, 0, 0);
        settle();

        $display("%0d/%0d checks passed", passed, total);
        $finish;
    end

endmodule